// File: doc/BRIEF.md
# Filter RC Tuning Calibration Controller

This block trims the capacitor array of an on-chip bandpass filter so that its RC product lands on target despite process spread. It runs a repeating measurement: a replica capacitor bank is first discharged and then charged for a fixed number of clock cycles. A single compare pulse then samples an external comparator, which reports whether the charging voltage has passed a reference. Depending on the answer, the capacitor code steps one count up or one count down.

The search is a linear tracker, not a binary search. It stops at the first iteration whose comparator decision differs from the one before it. It also stops when the code reaches either end of its range, or when the iteration budget runs out. Once it stops, the code is frozen for the filters, a done flag rises, and a power-down flag tells the analog replica circuitry to switch off.

A new calibration is started by a one-cycle start strobe. Only the clock, the strobe and the comparator output are inputs. The charging circuit and the comparator sit outside this block. All interfaces are plain control and status pins, so there is no streaming handshake and no back-pressure.

Top module: `rc_tune_ctrl`

## Requirements
- R1: During and directly after reset, `cap_code_o` equals CODE_INIT (default 16, mid-scale of a 5-bit code), `done_o` is 0, `pwr_dn_o` is 1, and `chg_en_o` and `cmp_clk_o` are 0.
- R2: Each iteration consists of DIS_CYC cycles with `chg_en_o` low, then CHG_CYC cycles with `chg_en_o` high, then exactly one cycle with `cmp_clk_o` high and `chg_en_o` still high.
- R3: `cmp_i` is sampled at the clock edge that ends the `cmp_clk_o` cycle. If it is 1, `cap_code_o` goes up by one; if it is 0, it goes down by one. The new code is visible in the next cycle.
- R4: When the sampled decision differs from the previous iteration's decision, that iteration's step is still applied and calibration ends.
- R5: When a step brings the code to 0 or to 2^CODE_W-1, calibration ends. The code never wraps.
- R6: No calibration runs more than MAX_ITER iterations; the iteration that reaches MAX_ITER ends it.
- R7: After calibration ends, `done_o` and `pwr_dn_o` are 1, and `chg_en_o` and `cmp_clk_o` are 0. `cap_code_o` holds its final value whatever `cmp_i` does, until the next accepted start.
- R8: `start_i` is accepted only while `pwr_dn_o` is 1. In the next cycle the code is back at CODE_INIT and `done_o` and `pwr_dn_o` are 0. A start while calibration runs has no effect on the result.
- R9: The first iteration after a start has no previous decision and never counts as a reversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a calibration |
| cmp_i | input | 1 | Comparator result, 1 when the charging voltage is above the reference |
| chg_en_o | output | 1 | Charge enable for the replica capacitor bank |
| cmp_clk_o | output | 1 | Compare pulse, one cycle per iteration |
| cap_code_o | output | CODE_W | Capacitor array code |
| done_o | output | 1 | Calibration finished, code frozen |
| pwr_dn_o | output | 1 | Power-down request for the calibration circuitry |

## Verification
A corrupted phase timer shows at the ports within one iteration: the count of cycles with `chg_en_o` high or low per compare pulse no longer matches DIS_CYC and CHG_CYC+1. A wrong step or saturation shows on `cap_code_o` in the cycle right after the compare pulse. A lost previous decision or iteration counter shows as a calibration that ends one or more iterations too late or too early, so the final code and the number of compare pulses are checked for each decision pattern. A leak of comparator or start activity into the finished state shows as a change of `cap_code_o` while `done_o` is high.

// File: rtl/rc_tune_pkg.sv
package rc_tune_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DIS  = 3'd1,
    PH_CHG  = 3'd2,
    PH_CMP  = 3'd3,
    PH_FIN  = 3'd4
  } phase_t;
endpackage

// File: rtl/rc_tune_seq.sv
// Phase sequencer: discharge, charge, compare; loops until the stepper
// flags the last iteration.
module rc_tune_seq
  import rc_tune_pkg::*;
#(
  parameter int DIS_CYC = 4,
  parameter int CHG_CYC = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go_i,
  input  logic   last_i,
  output phase_t phase_o
);
  localparam int LONGEST = (DIS_CYC > CHG_CYC) ? DIS_CYC : CHG_CYC;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] DIS_LOAD = TW'(DIS_CYC - 1);
  localparam logic [TW-1:0] CHG_LOAD = TW'(CHG_CYC - 1);

  phase_t        phase_q, phase_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    phase_d = phase_q;
    tmr_d   = tmr_q;
    unique case (phase_q)
      PH_IDLE, PH_FIN: begin
        if (go_i) begin
          phase_d = PH_DIS;
          tmr_d   = DIS_LOAD;
        end
      end
      PH_DIS: begin
        if (tmr_q == '0) begin
          phase_d = PH_CHG;
          tmr_d   = CHG_LOAD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PH_CHG: begin
        if (tmr_q == '0) phase_d = PH_CMP;
        else             tmr_d   = tmr_q - 1'b1;
      end
      PH_CMP: begin
        if (last_i) begin
          phase_d = PH_FIN;
        end else begin
          phase_d = PH_DIS;
          tmr_d   = DIS_LOAD;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/rc_tune_step.sv
// Code stepper: saturating up/down step, reversal and budget detection.
module rc_tune_step #(
  parameter int CODE_W    = 5,
  parameter int CODE_INIT = 16,
  parameter int MAX_ITER  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              sample_i,
  input  logic              dec_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o
);
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [CODE_W-1:0] TOP  = '1;
  localparam logic [CODE_W-1:0] INIT = CODE_W'(CODE_INIT);
  localparam logic [IW-1:0]     LAST_ITER = IW'(MAX_ITER - 1);

  logic [CODE_W-1:0] code_q, code_nx;
  logic              prev_q, seen_q;
  logic [IW-1:0]     iter_q;
  logic              flip, at_edge, out_of_budget;

  always_comb begin
    if (dec_i) code_nx = (code_q == TOP) ? code_q : code_q + 1'b1;
    else       code_nx = (code_q == '0)  ? code_q : code_q - 1'b1;
    flip          = seen_q && (dec_i != prev_q);
    at_edge       = (code_nx == TOP) || (code_nx == '0);
    out_of_budget = (iter_q == LAST_ITER);
    last_o        = flip || at_edge || out_of_budget;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= INIT;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      iter_q <= '0;
    end else if (load_i) begin
      code_q <= INIT;
      seen_q <= 1'b0;
      iter_q <= '0;
    end else if (sample_i) begin
      code_q <= code_nx;
      prev_q <= dec_i;
      seen_q <= 1'b1;
      iter_q <= iter_q + 1'b1;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/rc_tune_ctrl.sv
module rc_tune_ctrl
  import rc_tune_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int CODE_INIT = 16,
  parameter int MAX_ITER  = 32,
  parameter int DIS_CYC   = 4,
  parameter int CHG_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic              chg_en_o,
  output logic              cmp_clk_o,
  output logic [CODE_W-1:0] cap_code_o,
  output logic              done_o,
  output logic              pwr_dn_o
);
  phase_t phase;
  logic   parked, go, sample, last;

  assign parked = (phase == PH_IDLE) || (phase == PH_FIN);
  assign go     = start_i && parked;
  assign sample = (phase == PH_CMP);

  rc_tune_seq #(
    .DIS_CYC(DIS_CYC),
    .CHG_CYC(CHG_CYC)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .last_i (last),
    .phase_o(phase)
  );

  rc_tune_step #(
    .CODE_W   (CODE_W),
    .CODE_INIT(CODE_INIT),
    .MAX_ITER (MAX_ITER)
  ) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (go),
    .sample_i(sample),
    .dec_i   (cmp_i),
    .code_o  (cap_code_o),
    .last_o  (last)
  );

  assign chg_en_o  = (phase == PH_CHG) || (phase == PH_CMP);
  assign cmp_clk_o = sample;
  assign done_o    = (phase == PH_FIN);
  assign pwr_dn_o  = parked;
endmodule

// File: rtl/rc_tune_chk.sv
module rc_tune_chk #(
  parameter int CODE_W    = 5,
  parameter int CODE_INIT = 16,
  parameter int MAX_ITER  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cmp_i,
  input logic              chg_en_o,
  input logic              cmp_clk_o,
  input logic [CODE_W-1:0] cap_code_o,
  input logic              done_o,
  input logic              pwr_dn_o
);
  localparam int IW = $clog2(MAX_ITER + 1) + 1;
  localparam logic [CODE_W-1:0] TOP = '1;

  logic [IW-1:0] pulses;
  logic          prev_dec, have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses    <= '0;
      prev_dec  <= 1'b0;
      have_prev <= 1'b0;
    end else if (start_i && pwr_dn_o) begin
      pulses    <= '0;
      have_prev <= 1'b0;
    end else if (cmp_clk_o) begin
      pulses    <= pulses + 1'b1;
      prev_dec  <= cmp_i;
      have_prev <= 1'b1;
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_clk_o |=> !cmp_clk_o);
  assert_charge_at_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_clk_o |-> chg_en_o);
  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clk_o && cmp_i && cap_code_o != TOP) |=> cap_code_o == CODE_W'($past(cap_code_o) + 1'b1));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clk_o && !cmp_i && cap_code_o != '0) |=> cap_code_o == CODE_W'($past(cap_code_o) - 1'b1));
  assert_reversal_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clk_o && have_prev && cmp_i != prev_dec) |=> done_o);
  assert_top_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clk_o && cmp_i && cap_code_o == TOP - 1'b1) |=> done_o);
  assert_bottom_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clk_o && !cmp_i && cap_code_o == CODE_W'(1)) |=> done_o);
  assert_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= IW'(MAX_ITER));
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pwr_dn_o && !chg_en_o && !cmp_clk_o));
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_clk_o && !(start_i && pwr_dn_o)) |=> $stable(cap_code_o));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pwr_dn_o) |=> (!pwr_dn_o && !done_o && cap_code_o == CODE_W'(CODE_INIT)));
endmodule

bind rc_tune_ctrl rc_tune_chk #(
  .CODE_W   (CODE_W),
  .CODE_INIT(CODE_INIT),
  .MAX_ITER (MAX_ITER)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .cmp_i     (cmp_i),
  .chg_en_o  (chg_en_o),
  .cmp_clk_o (cmp_clk_o),
  .cap_code_o(cap_code_o),
  .done_o    (done_o),
  .pwr_dn_o  (pwr_dn_o)
);

// File: tb/tb_rc_tune_ctrl.sv
module tb_rc_tune_ctrl;
  localparam int CW   = 5;
  localparam int INIT = 27;
  localparam int MAXI = 6;
  localparam int DIS  = 2;
  localparam int CHG  = 3;
  localparam int NV   = 6;

  // {decision pattern (bit k = decision of iteration k), final code, iterations}
  localparam logic [16:0] VEC [NV] = '{
    {8'hFF, 5'd31, 4'd4},   // R5 upper limit, R9 first iteration
    {8'h00, 5'd21, 4'd6},   // R6 budget
    {8'h03, 5'd28, 4'd3},   // R4 up,up,down
    {8'h02, 5'd27, 4'd2},   // R4 down,up
    {8'h20, 5'd23, 4'd6},   // R4 and R6 together
    {8'h01, 5'd27, 4'd2}    // R4 up,down
  };
  localparam string TAG [NV] = '{"R5 R9", "R6", "R4", "R4", "R4 R6", "R4"};

  logic          clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, cmp_i = 1'b0;
  logic          chg_en_o, cmp_clk_o, done_o, pwr_dn_o;
  logic [CW-1:0] cap_code_o;
  int            n_run = 0, n_fail = 0;

  rc_tune_ctrl #(.CODE_W(CW), .CODE_INIT(INIT), .MAX_ITER(MAXI),
                 .DIS_CYC(DIS), .CHG_CYC(CHG)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .chg_en_o(chg_en_o), .cmp_clk_o(cmp_clk_o), .cap_code_o(cap_code_o),
    .done_o(done_o), .pwr_dn_o(pwr_dn_o));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input bit d);
    if (d) return (c == '1) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction

  task automatic run(input logic [7:0] pat, input int glitch,
                     output int iters, output int hi, output int lo);
    int            k = 0;
    bit            pulsed = 0, chk_next = 0;
    logic [CW-1:0] exp = CW'(INIT);
    hi = 0;
    lo = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(cap_code_o == CW'(INIT) && !done_o && !pwr_dn_o, "R8 restart code", cap_code_o, INIT);
    while (!done_o) begin
      if (chk_next) begin
        check(cap_code_o == exp, "R3 step", cap_code_o, exp);
        chk_next = 0;
      end
      if (chg_en_o) hi++; else lo++;
      cmp_i   = pat[k];
      start_i = 1'b0;
      if (cmp_clk_o) begin
        exp = step(exp, pat[k]);
        k++;
        chk_next = 1;
      end else if (k == glitch && !pulsed) begin
        start_i = 1'b1;
        pulsed  = 1;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    if (chk_next) check(cap_code_o == exp, "R3 last step", cap_code_o, exp);
    iters = k;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int it, hi, lo;
    repeat (3) @(negedge clk);
    check(cap_code_o == CW'(INIT), "R1 reset code", cap_code_o, INIT);
    check(!done_o && pwr_dn_o, "R1 reset flags", {done_o, pwr_dn_o}, 1);
    check(!chg_en_o && !cmp_clk_o, "R1 reset drives", {chg_en_o, cmp_clk_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!chg_en_o && pwr_dn_o, "R1 idle after reset", {chg_en_o, pwr_dn_o}, 1);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][16:9], -1, it, hi, lo);
      check(cap_code_o == VEC[i][8:4], {TAG[i], " final code"}, cap_code_o, VEC[i][8:4]);
      check(it == int'(VEC[i][3:0]), {TAG[i], " iterations"}, it, VEC[i][3:0]);
      check(hi == it * (CHG + 1), "R2 charge cycles", hi, it * (CHG + 1));
      check(lo == it * DIS, "R2 discharge cycles", lo, it * DIS);
      check(done_o && pwr_dn_o, "R7 done flags", {done_o, pwr_dn_o}, 3);
    end

    // R7: comparator activity after completion is ignored
    for (int c = 0; c < 8; c++) begin
      cmp_i = c[0];
      @(negedge clk);
      check(cap_code_o == 5'd27 && !chg_en_o && !cmp_clk_o && done_o,
            "R7 code frozen", cap_code_o, 27);
    end

    // R8: start during calibration is ignored
    run(8'h03, 1, it, hi, lo);
    check(cap_code_o == 5'd28, "R8 mid-run start code", cap_code_o, 28);
    check(it == 3, "R8 mid-run start iterations", it, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule